// File: doc/BRIEF.md
# PWM Event Trigger Prescaler

This block sits beside a PWM time-base counter. It turns the counter's match strobes into three output pulses: one interrupt request and two ADC start-of-conversion requests (A and B). Each output is a channel with its own settings:

- an event source;
- an enable bit;
- a 2-bit period that passes every first, second or third event, or none;
- a sticky status flag.

Software sets these through a small word-addressed register bus. It can clear flags or force an event into any channel by writing ones.

Compare-A and compare-B matches are first split by the count direction. This gives six events: counter at zero, counter at period, and compare A or compare B while counting up or while counting down.

Each channel counts its events in a small state machine with three states:

- `CNT0`: no events held.
- `CNT1`: one event held.
- `CNT2`: two events held.

The state moves on every event that is let through. There are two transitions:

- **advance**: `CNT0`→`CNT1` and `CNT1`→`CNT2`, taken when the period is not yet reached.
- **fire**: any state →`CNT0`, taken when the held count plus one reaches or passes the period. It also issues a one-cycle pulse and sets the flag.

The interrupt channel also holds, ignoring events, while its flag is set.

Top module: `pwm_evt_trig`

## Requirements
- R1: After reset, all three pulses are low. Every readable register returns zero, including the event counts and the flags.
- R2: Source codes in a channel's 3-bit select field are: 1 zero match, 2 period match, 3 compare A counting up, 4 compare A counting down, 5 compare B counting up, 6 compare B counting down. Codes 0 and 7 select nothing. `cnt_up` high means counting up.
- R3: The period field works as follows. 0 gives no pulse and leaves the count unchanged. N = 1..3 gives a pulse on every Nth event. The 2-bit count rises on each event and returns to 0 when the pulse fires.
- R4: A pulse sets that channel's flag. The flag register holds the flags at bit 0 (interrupt), bit 1 (SOC A) and bit 2 (SOC B).
- R5: Writing 1 to a bit of the clear register resets that flag. A flag being set in the same cycle as its clear stays set.
- R6: Writing 1 to a bit of the force register injects one event into that channel. A force and a real event in the same cycle count as one event.
- R7: While a channel's enable bit is 0, it ignores real and forced events. It produces no pulse and holds its count.
- R8: While the interrupt flag is set, the interrupt channel ignores events and holds its count. No further interrupt pulse is issued until the flag is cleared.
- R9: Each pulse is high for exactly the one cycle after the clock edge that sampled the event.
- R10: The registers are at the following word offsets. In each register with fields, channel c owns the nibble at bits 4c+3..4c, with channel 0 the interrupt, 1 SOC A and 2 SOC B.
  - 0x19, select: bits [2:0] source, bit 3 enable.
  - 0x1A, prescale: bits [1:0] period; bits [3:2] count, read-only.
  - 0x1B, flags.
  - 0x1C, clear.
  - 0x1D, force.

  A write takes effect at the next clock edge. The clear and force registers, and any unmapped offset, read as zero.
- R11: If the period is lowered to or below the held count, the next event fires the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_zero | input | 1 | Counter-equals-zero strobe |
| ctr_period | input | 1 | Counter-equals-period strobe |
| cmpa_hit | input | 1 | Counter-equals-compare-A strobe |
| cmpb_hit | input | 1 | Counter-equals-compare-B strobe |
| cnt_up | input | 1 | Count direction, 1 = up |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register word offset |
| bus_wdata | input | DATA_W (12) | Write data |
| bus_rdata | output | DATA_W (12) | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | Interrupt pulse |
| soca_pulse | output | 1 | Start-of-conversion A pulse |
| socb_pulse | output | 1 | Start-of-conversion B pulse |

## Verification
The bench builds the block with its default parameters: DATA_W 12, ADDR_W 5 and BASE_ADDR 0x19. At these values all three channel nibbles fit the data word, and the five registers land at offsets 0x19 to 0x1D. Period 3 drives the count to its top state `CNT2`. The interrupt channel is the only one that holds on its flag, so both the holding and the free-running channel behaviours can be exercised. The same-cycle cases are all within reach: a force with a real event, a set with a clear, and a period lowered beneath a held count.

// File: rtl/evt_trig_pkg.sv
`timescale 1ns/1ps
package evt_trig_pkg;

    localparam int NCH   = 3;
    localparam int SRC_W = 3;
    localparam int PRD_W = 2;
    localparam int FLD_W = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 3'd0,
        SRC_ZERO   = 3'd1,
        SRC_PERIOD = 3'd2,
        SRC_A_UP   = 3'd3,
        SRC_A_DN   = 3'd4,
        SRC_B_UP   = 3'd5,
        SRC_B_DN   = 3'd6,
        SRC_OFF    = 3'd7
    } src_e;

    typedef enum logic [PRD_W-1:0] {
        CNT0 = 2'd0,
        CNT1 = 2'd1,
        CNT2 = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic zero;
        logic period;
        logic a_up;
        logic a_dn;
        logic b_up;
        logic b_dn;
    } match_t;

endpackage

// File: rtl/evt_dir_split.sv
`timescale 1ns/1ps
module evt_dir_split
    import evt_trig_pkg::*;
(
    input  logic   zero_i,
    input  logic   period_i,
    input  logic   cmpa_i,
    input  logic   cmpb_i,
    input  logic   up_i,
    output match_t match_o
);

    // Compare strobes are qualified by direction; the others pass through.
    always_comb begin
        match_o.zero   = zero_i;
        match_o.period = period_i;
        match_o.a_up   = cmpa_i && up_i;
        match_o.a_dn   = cmpa_i && !up_i;
        match_o.b_up   = cmpb_i && up_i;
        match_o.b_dn   = cmpb_i && !up_i;
    end

endmodule

// File: rtl/evt_source_mux.sv
`timescale 1ns/1ps
module evt_source_mux
    import evt_trig_pkg::*;
(
    input  match_t           match_i,
    input  logic [SRC_W-1:0] src_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = 1'b0;
        unique case (src_e'(src_i))
            SRC_ZERO:          hit_o = match_i.zero;
            SRC_PERIOD:        hit_o = match_i.period;
            SRC_A_UP:          hit_o = match_i.a_up;
            SRC_A_DN:          hit_o = match_i.a_dn;
            SRC_B_UP:          hit_o = match_i.b_up;
            SRC_B_DN:          hit_o = match_i.b_dn;
            SRC_NONE, SRC_OFF: hit_o = 1'b0;
            default:           hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evt_prescale_chan.sv
`timescale 1ns/1ps
module evt_prescale_chan
    import evt_trig_pkg::*;
#(
    parameter bit HOLD_ON_FLAG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             force_i,
    input  logic             enable_i,
    input  logic [PRD_W-1:0] prd_i,
    input  logic             clr_i,
    output logic             pulse_o,
    output logic             flag_o,
    output logic [PRD_W-1:0] cnt_o
);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic             flag_q;
    logic             pulse_q;
    logic             blocked;
    logic             evt;
    logic             fire;
    logic [PRD_W:0]   cnt_inc;

    // A pending flag stalls the channel only in the holding variant.
    assign blocked = HOLD_ON_FLAG && flag_q;

    // Force and real event merge into a single event.
    assign evt     = (hit_i || force_i) && enable_i
                     && (prd_i != '0) && !blocked;
    assign cnt_inc = {1'b0, state_q} + (PRD_W+1)'(1);
    assign fire    = evt && (cnt_inc >= {1'b0, prd_i});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT0;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: advance or fire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT0:    if (evt) state_d = fire ? CNT0 : CNT1;
            CNT1:    if (evt) state_d = fire ? CNT0 : CNT2;
            CNT2:    if (evt) state_d = CNT0;
            default: state_d = CNT0;
        endcase
    end

    // Outputs: one-cycle pulse and sticky flag (set beats clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= fire;
            flag_q  <= fire || (flag_q && !clr_i);
        end
    end

    assign pulse_o = pulse_q;
    assign flag_o  = flag_q;
    assign cnt_o   = state_q;

endmodule

// File: rtl/evt_reg_bank.sv
`timescale 1ns/1ps
module evt_reg_bank
    import evt_trig_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int ADDR_W    = 5,
    parameter int BASE_ADDR = 25
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [NCH-1:0]         flag_i,
    input  logic [NCH*PRD_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [NCH*SRC_W-1:0]   src_o,
    output logic [NCH-1:0]         en_o,
    output logic [NCH*PRD_W-1:0]   prd_o,
    output logic [NCH-1:0]         clr_o,
    output logic [NCH-1:0]         frc_o
);

    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_PRS = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(BASE_ADDR + 2);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_ADDR + 3);
    localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(BASE_ADDR + 4);

    logic wr_sel;
    logic wr_prs;
    logic wr_clr;
    logic wr_frc;
    logic [NCH*SRC_W-1:0] src_q;
    logic [NCH-1:0]       en_q;
    logic [NCH*PRD_W-1:0] prd_q;

    assign wr_sel = bus_wr && (bus_addr == A_SEL);
    assign wr_prs = bus_wr && (bus_addr == A_PRS);
    assign wr_clr = bus_wr && (bus_addr == A_CLR);
    assign wr_frc = bus_wr && (bus_addr == A_FRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            en_q  <= '0;
            prd_q <= '0;
        end else begin
            if (wr_sel) begin
                for (int c = 0; c < NCH; c++) begin
                    src_q[c*SRC_W +: SRC_W] <= bus_wdata[c*FLD_W +: SRC_W];
                    en_q[c]                 <= bus_wdata[c*FLD_W + SRC_W];
                end
            end
            if (wr_prs) begin
                for (int c = 0; c < NCH; c++) begin
                    prd_q[c*PRD_W +: PRD_W] <= bus_wdata[c*FLD_W +: PRD_W];
                end
            end
        end
    end

    // Write-one strobes act in the cycle of the write
    assign clr_o = wr_clr ? bus_wdata[NCH-1:0] : '0;
    assign frc_o = wr_frc ? bus_wdata[NCH-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SEL: begin
                for (int c = 0; c < NCH; c++) begin
                    bus_rdata[c*FLD_W +: SRC_W] = src_q[c*SRC_W +: SRC_W];
                    bus_rdata[c*FLD_W + SRC_W]  = en_q[c];
                end
            end
            A_PRS: begin
                for (int c = 0; c < NCH; c++) begin
                    bus_rdata[c*FLD_W +: PRD_W]         = prd_q[c*PRD_W +: PRD_W];
                    bus_rdata[c*FLD_W + PRD_W +: PRD_W] = cnt_i[c*PRD_W +: PRD_W];
                end
            end
            A_FLG:   bus_rdata[NCH-1:0] = flag_i;
            default: bus_rdata = '0;
        endcase
    end

    assign src_o = src_q;
    assign en_o  = en_q;
    assign prd_o = prd_q;

endmodule

// File: rtl/pwm_evt_trig.sv
`timescale 1ns/1ps
module pwm_evt_trig
    import evt_trig_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int ADDR_W    = 5,
    parameter int BASE_ADDR = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctr_zero,
    input  logic              ctr_period,
    input  logic              cmpa_hit,
    input  logic              cmpb_hit,
    input  logic              cnt_up,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse,
    output logic              soca_pulse,
    output logic              socb_pulse
);

    match_t               match;
    logic [NCH*SRC_W-1:0] src_w;
    logic [NCH-1:0]       en_w;
    logic [NCH*PRD_W-1:0] prd_w;
    logic [NCH-1:0]       clr_w;
    logic [NCH-1:0]       frc_w;
    logic [NCH-1:0]       hit_w;
    logic [NCH-1:0]       pulse_w;
    logic [NCH-1:0]       flag_w;
    logic [NCH*PRD_W-1:0] cnt_w;

    evt_dir_split u_split (
        .zero_i   (ctr_zero),
        .period_i (ctr_period),
        .cmpa_i   (cmpa_hit),
        .cmpb_i   (cmpb_hit),
        .up_i     (cnt_up),
        .match_o  (match)
    );

    evt_reg_bank #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag_i    (flag_w),
        .cnt_i     (cnt_w),
        .bus_rdata (bus_rdata),
        .src_o     (src_w),
        .en_o      (en_w),
        .prd_o     (prd_w),
        .clr_o     (clr_w),
        .frc_o     (frc_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        evt_source_mux u_mux (
            .match_i (match),
            .src_i   (src_w[c*SRC_W +: SRC_W]),
            .hit_o   (hit_w[c])
        );

        // Channel 0 (interrupt) holds while its flag is pending
        evt_prescale_chan #(
            .HOLD_ON_FLAG ((c == 0) ? 1'b1 : 1'b0)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit_w[c]),
            .force_i  (frc_w[c]),
            .enable_i (en_w[c]),
            .prd_i    (prd_w[c*PRD_W +: PRD_W]),
            .clr_i    (clr_w[c]),
            .pulse_o  (pulse_w[c]),
            .flag_o   (flag_w[c]),
            .cnt_o    (cnt_w[c*PRD_W +: PRD_W])
        );
    end

    assign irq_pulse  = pulse_w[0];
    assign soca_pulse = pulse_w[1];
    assign socb_pulse = pulse_w[2];

endmodule

// File: rtl/evt_trig_chk.sv
`timescale 1ns/1ps
module evt_trig_chk #(
    parameter int NCH       = 3,
    parameter int DATA_W    = 12,
    parameter int ADDR_W    = 5,
    parameter int BASE_ADDR = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    pulse,
    input logic [NCH-1:0]    flag,
    input logic [NCH-1:0]    en,
    input logic [NCH*2-1:0]  prd,
    input logic [NCH*2-1:0]  cnt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_ADDR + 3);
    localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(BASE_ADDR + 4);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R4
        pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[c] |-> flag[c]);

        // R7
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en[c]) |-> !pulse[c]);

        // R3
        prd_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prd[c*2 +: 2] == 2'd0) |=> $stable(cnt[c*2 +: 2]));
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag[0] |=> !pulse[0]);

    // R10
    strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == A_CLR) || (bus_addr == A_FRC)) |-> (bus_rdata == '0));

endmodule

bind pwm_evt_trig evt_trig_chk #(
    .NCH       (3),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse     (pulse_w),
    .flag      (flag_w),
    .en        (en_w),
    .prd       (prd_w),
    .cnt       (cnt_w),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_pwm_evt_trig.sv
`timescale 1ns/1ps
module sim_pwm_evt_trig;

    localparam logic [4:0] A_SEL = 5'h19;
    localparam logic [4:0] A_PRS = 5'h1A;
    localparam logic [4:0] A_FLG = 5'h1B;
    localparam logic [4:0] A_CLR = 5'h1C;
    localparam logic [4:0] A_FRC = 5'h1D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctr_zero = 1'b0;
    logic        ctr_period = 1'b0;
    logic        cmpa_hit = 1'b0;
    logic        cmpb_hit = 1'b0;
    logic        cnt_up = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic        irq_pulse;
    logic        soca_pulse;
    logic        socb_pulse;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    logic [11:0] sel_sh = '0;
    logic [11:0] prs_sh = '0;
    logic [11:0] rv;

    always #2.5 clk = ~clk;

    pwm_evt_trig u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctr_zero   (ctr_zero),
        .ctr_period (ctr_period),
        .cmpa_hit   (cmpa_hit),
        .cmpb_hit   (cmpb_hit),
        .cnt_up     (cnt_up),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pulse  (irq_pulse),
        .soca_pulse (soca_pulse),
        .socb_pulse (socb_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [11:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [11:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_of(input int c, output logic [1:0] v);
        logic [11:0] t;
        rd(A_PRS, t);
        v = t[c*4+2 +: 2];
    endtask

    task automatic cfg(input int c, input logic [2:0] src, input logic en, input logic [1:0] prd);
        sel_sh[c*4 +: 3] = src;
        sel_sh[c*4+3]    = en;
        wr(A_SEL, sel_sh);
        prs_sh[c*4 +: 2] = prd;
        wr(A_PRS, prs_sh);
    endtask

    // 0 zero, 1 period, 2 cmpA up, 3 cmpA down, 4 cmpB up, 5 cmpB down
    task automatic ev(input int pat);
        ctr_zero   = (pat == 0);
        ctr_period = (pat == 1);
        cmpa_hit   = (pat == 2) || (pat == 3);
        cmpb_hit   = (pat == 4) || (pat == 5);
        cnt_up     = !((pat == 3) || (pat == 5));
        tick();
        ctr_zero = 0; ctr_period = 0; cmpa_hit = 0; cmpb_hit = 0; cnt_up = 1;
    endtask

    task automatic t_reset();
        rd(A_SEL, rv); check("R1 sel", rv, 0);
        rd(A_PRS, rv); check("R1 prescale", rv, 0);
        rd(A_FLG, rv); check("R1 flags", rv, 0);
        check("R1 pulses", {irq_pulse, soca_pulse, socb_pulse}, 0);
    endtask

    task automatic t_select();
        for (int code = 0; code < 8; code++) begin
            cfg(1, 3'(code), 1'b1, 2'd1);
            for (int pat = 0; pat < 6; pat++) begin
                ev(pat);
                check($sformatf("R2 code%0d pat%0d", code, pat), soca_pulse, (code == pat + 1));
                check("R2 other channels quiet", {irq_pulse, socb_pulse}, 0);
            end
        end
    endtask

    task automatic t_prescale();
        logic [1:0] c;
        cfg(2, 3'd1, 1'b1, 2'd3);
        ev(0); count_of(2, c); check("R3 p3 ev1 pulse", socb_pulse, 0); check("R3 p3 cnt1", c, 1);
        ev(0); count_of(2, c); check("R3 p3 ev2 pulse", socb_pulse, 0); check("R3 p3 cnt2", c, 2);
        ev(0); count_of(2, c); check("R3 p3 ev3 pulse", socb_pulse, 1); check("R3 p3 cnt0", c, 0);
        cfg(2, 3'd1, 1'b1, 2'd2);
        ev(0); count_of(2, c); check("R3 p2 ev1 pulse", socb_pulse, 0); check("R3 p2 cnt1", c, 1);
        ev(0); count_of(2, c); check("R3 p2 ev2 pulse", socb_pulse, 1); check("R3 p2 cnt0", c, 0);
        cfg(2, 3'd1, 1'b1, 2'd0);
        ev(0); count_of(2, c); check("R3 p0 pulse", socb_pulse, 0); check("R3 p0 cnt", c, 0);
    endtask

    task automatic t_flags();
        rd(A_FLG, rv); check("R4 flags after pulses", rv, 12'b110);
        wr(A_CLR, 12'b100);
        rd(A_FLG, rv); check("R5 clear socb flag", rv, 12'b010);
        wr(A_CLR, 12'b010);
        rd(A_FLG, rv); check("R5 clear soca flag", rv, 12'b000);
        cfg(1, 3'd1, 1'b1, 2'd1);
        ctr_zero = 1'b1;
        wr(A_CLR, 12'b010);
        ctr_zero = 1'b0;
        check("R5 set with clear pulse", soca_pulse, 1);
        rd(A_FLG, rv); check("R5 set beats clear", rv, 12'b010);
    endtask

    task automatic t_force();
        logic [1:0] c;
        cfg(2, 3'd2, 1'b1, 2'd1);
        wr(A_FRC, 12'b100);
        check("R6 force pulse", socb_pulse, 1);
        tick();
        check("R9 pulse one cycle", socb_pulse, 0);
        cfg(2, 3'd1, 1'b1, 2'd2);
        ctr_zero = 1'b1;
        wr(A_FRC, 12'b100);
        ctr_zero = 1'b0;
        count_of(2, c);
        check("R6 merged no pulse", socb_pulse, 0);
        check("R6 merged counts once", c, 1);
        ev(0); count_of(2, c);
        check("R6 second event pulse", socb_pulse, 1);
        check("R6 second event cnt", c, 0);
    endtask

    task automatic t_enable();
        logic [1:0] c;
        cfg(2, 3'd1, 1'b0, 2'd2);
        ev(0); count_of(2, c); check("R7 off ev1 pulse", socb_pulse, 0); check("R7 off ev1 cnt", c, 0);
        ev(0); count_of(2, c); check("R7 off ev2 pulse", socb_pulse, 0); check("R7 off ev2 cnt", c, 0);
        wr(A_FRC, 12'b100); count_of(2, c);
        check("R7 off force pulse", socb_pulse, 0); check("R7 off force cnt", c, 0);
    endtask

    task automatic t_irq_hold();
        logic [1:0] c;
        wr(A_CLR, 12'b111);
        cfg(0, 3'd1, 1'b1, 2'd1);
        ev(0); check("R8 first irq", irq_pulse, 1);
        rd(A_FLG, rv); check("R4 irq flag", rv[0], 1);
        ev(0); check("R8 held irq", irq_pulse, 0);
        cfg(0, 3'd1, 1'b1, 2'd2);
        ev(0); count_of(0, c); check("R8 held cnt", c, 0);
        wr(A_CLR, 12'b001);
        ev(0); count_of(0, c); check("R8 released ev1 pulse", irq_pulse, 0); check("R8 released cnt", c, 1);
        ev(0); check("R8 released ev2 pulse", irq_pulse, 1);
        tick(); check("R9 irq one cycle", irq_pulse, 0);
    endtask

    task automatic t_lower();
        logic [1:0] c;
        cfg(1, 3'd1, 1'b1, 2'd3);
        ev(0); ev(0); count_of(1, c);
        check("R11 held pulse", soca_pulse, 0); check("R11 held cnt", c, 2);
        cfg(1, 3'd1, 1'b1, 2'd1);
        count_of(1, c); check("R11 cnt kept", c, 2);
        ev(0); count_of(1, c);
        check("R11 lowered fires", soca_pulse, 1); check("R11 cnt reset", c, 0);
    endtask

    task automatic t_map();
        rd(A_SEL, rv); check("R10 sel readback", rv, sel_sh);
        rd(A_CLR, rv); check("R10 clear reads 0", rv, 0);
        rd(A_FRC, rv); check("R10 force reads 0", rv, 0);
        rd(5'h00, rv); check("R10 unmapped reads 0", rv, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_select();
        t_prescale();
        t_flags();
        t_force();
        t_enable();
        t_irq_hold();
        t_lower();
        t_map();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule